// File: doc/BRIEF.md
# Direct-Mode Serial Output Register Decoder

This block is the serial front end of an eight-channel output controller that is driven without command bytes. A host writes a frame over a four-wire SPI link, and when chip select is released the frame's contents land in the controller's drive registers. These are the per-channel output level, the high-side or push-pull selection, and the open-load detection enable. The frame format is set by two static inputs. A size input selects 8-bit or 16-bit frames. A config input selects which registers the frame writes.

While a frame is shifted in, the block shifts out the status captured when the previous frame ended. A narrow frame returns the fault bits. A wide frame returns the fault bits followed by the level bits. Current status therefore takes two frames to read. The serial pins are oversampled by a faster system clock after synchronisation. A frame whose length does not match the selected size is dropped.

Top module: `odrv_spi_direct`

## Requirements
- R1: With size low and config low, a complete 8-bit frame writes the output-level register and leaves the mode and open-load registers unchanged.
- R2: With size low and config high, a complete 8-bit frame writes the high-side/push-pull register (bit = 1 means push-pull) and leaves level and open-load unchanged.
- R3: With size high and config low, a complete 16-bit frame writes its first byte to the level register and its second byte to the push-pull register, and leaves open-load unchanged.
- R4: With size high and config high, a complete 16-bit frame writes its first byte to the push-pull register and its second byte to the open-load enable register, and leaves level unchanged.
- R5: During a frame, SDO presents the fault byte (channel 7 first) in 8-bit mode. In 16-bit mode it presents the fault byte and then the level byte (channel 7 first in each).
- R6: The returned fault and level bytes are the status inputs sampled when the previous frame ended (chip select rising). This holds whether or not that frame was accepted.
- R7: A frame whose SCLK rising-edge count differs from the selected length (8 or 16) changes no register.
- R8: After reset, all three registers are zero (outputs off, high-side, open-load detection off). The first frame returns all zeros, and SDO is low while chip select is high.
- R9: SDI is sampled on SCLK rising edges, MSB first, so the first bit of each byte lands in channel 7. SDO advances on SCLK falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial status data to host |
| wide_sel | input | 1 | Frame size: 0 = 8 bits, 1 = 16 bits |
| cfg_sel | input | 1 | Register group selector (see R1 to R4) |
| flt_in | input | 8 | Per-channel fault status |
| lvl_in | input | 8 | Per-channel output level status |
| drv_level | output | 8 | Output-level register |
| drv_pp | output | 8 | Push-pull (1) / high-side (0) register |
| ol_en | output | 8 | Open-load detection enable register |

## Verification
The hardest condition to reach from the ports is the split between the frame's data and its returned status. Every reply belongs to the frame before, so a stale or premature snapshot can only be seen if the status inputs change between frames. The bench therefore sets new fault and level values before each frame and keeps its own snapshot model. Frames of the wrong length are sent in both sizes: an 8-bit frame in wide mode, plus 9-bit and 16-bit frames in narrow mode. This shows they alter no register but still advance the snapshot.

// File: rtl/odrv_spi_pkg.sv
package odrv_spi_pkg;
   typedef enum logic [1:0] {
      FMT_NARROW_LVL = 2'b00,
      FMT_NARROW_PP  = 2'b01,
      FMT_WIDE_LVLPP = 2'b10,
      FMT_WIDE_PPOL  = 2'b11
   } frame_fmt_e;

   function automatic frame_fmt_e fmt_of(input logic wide, input logic cfg);
      return frame_fmt_e'({wide, cfg});
   endfunction
endpackage

// File: rtl/odrv_pin_sync.sv
module odrv_pin_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   input  logic [WIDTH-1:0] rst_val,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("odrv_pin_sync: STAGES must be non-negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= rst_val;
               else if (s == 0) stage_q[s] <= async_in;
               else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/odrv_spi_shifter.sv
module odrv_spi_shifter #(
   parameter int CH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_s,
   input  logic          cs_n_s,
   input  logic          sdi_s,
   input  logic          wide_sel,
   input  logic [CH-1:0] snap_flt,
   input  logic [CH-1:0] snap_lvl,
   output logic          sdo,
   output logic [2*CH-1:0] rx_word,
   output logic          frame_end,
   output logic          frame_ok
);
   localparam int FW   = 2 * CH;
   localparam int CMAX = FW + 1;
   localparam int CW   = $clog2(CMAX + 1);

   logic          sclk_d, cs_d;
   logic          rise, fall, cs_fall, active;
   logic [CW-1:0] bit_cnt;
   logic [FW-1:0] tx_q;

   assign rise      = sclk_s & ~sclk_d;
   assign fall      = ~sclk_s & sclk_d;
   assign cs_fall   = ~cs_n_s & cs_d;
   assign frame_end = cs_n_s & ~cs_d;
   assign active    = ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cs_d    <= 1'b1;
         bit_cnt <= '0;
         rx_word <= '0;
         tx_q    <= '0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_n_s;
         if (cs_fall) begin
            bit_cnt <= '0;
            tx_q    <= {snap_flt, (wide_sel ? snap_lvl : {CH{1'b0}})};
         end else if (active) begin
            if (rise) begin
               rx_word <= {rx_word[FW-2:0], sdi_s};
               if (bit_cnt != CW'(CMAX)) bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall) tx_q <= {tx_q[FW-2:0], 1'b0};
         end
      end
   end

   assign sdo      = active & tx_q[FW-1];
   assign frame_ok = (bit_cnt == (wide_sel ? CW'(FW) : CW'(CH)));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CW'(CMAX)); // R7
   AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> !sdo); // R8
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !fall && !cs_fall && $past(active)) |=> $stable(sdo) || $past(cs_n_s) || !active || $past(fall)); // R9
endmodule

// File: rtl/odrv_reg_bank.sv
module odrv_reg_bank
   import odrv_spi_pkg::*;
#(
   parameter int CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_end,
   input  logic            frame_ok,
   input  logic            wide_sel,
   input  logic            cfg_sel,
   input  logic [2*CH-1:0] rx_word,
   input  logic [CH-1:0]   flt_in,
   input  logic [CH-1:0]   lvl_in,
   output logic [CH-1:0]   snap_flt,
   output logic [CH-1:0]   snap_lvl,
   output logic [CH-1:0]   level_q,
   output logic [CH-1:0]   pp_q,
   output logic [CH-1:0]   ol_q
);
   logic [CH-1:0] hi_b, lo_b;
   frame_fmt_e    fmt;

   assign hi_b = rx_word[2*CH-1:CH];
   assign lo_b = rx_word[CH-1:0];
   assign fmt  = fmt_of(wide_sel, cfg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q  <= '0;
         pp_q     <= '0;
         ol_q     <= '0;
         snap_flt <= '0;
         snap_lvl <= '0;
      end else if (frame_end) begin
         snap_flt <= flt_in;
         snap_lvl <= lvl_in;
         if (frame_ok) begin
            unique case (fmt)
               FMT_NARROW_LVL: level_q <= lo_b;
               FMT_NARROW_PP:  pp_q    <= lo_b;
               FMT_WIDE_LVLPP: begin level_q <= hi_b; pp_q <= lo_b; end
               FMT_WIDE_PPOL:  begin pp_q    <= hi_b; ol_q <= lo_b; end
               default: ;
            endcase
         end
      end
   end

   AST_BAD_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_ok) |=> ($stable(level_q) && $stable(pp_q) && $stable(ol_q))); // R7
   AST_NARROW_LVL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ok && !wide_sel && !cfg_sel) |=> ($stable(pp_q) && $stable(ol_q))); // R1
   AST_NARROW_PP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ok && !wide_sel && cfg_sel) |=> ($stable(level_q) && $stable(ol_q))); // R2
   AST_WIDE_KEEP_OL: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ok && wide_sel && !cfg_sel) |=> $stable(ol_q)); // R3
   AST_WIDE_KEEP_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ok && wide_sel && cfg_sel) |=> $stable(level_q)); // R4
   AST_REGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> ($stable(level_q) && $stable(pp_q) && $stable(ol_q) && $stable(snap_flt))); // R6
endmodule

// File: rtl/odrv_spi_direct.sv
module odrv_spi_direct #(
   parameter int CHANNELS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                sdi,
   output logic                sdo,
   input  logic                wide_sel,
   input  logic                cfg_sel,
   input  logic [CHANNELS-1:0] flt_in,
   input  logic [CHANNELS-1:0] lvl_in,
   output logic [CHANNELS-1:0] drv_level,
   output logic [CHANNELS-1:0] drv_pp,
   output logic [CHANNELS-1:0] ol_en
);
   localparam int FW = 2 * CHANNELS;

   generate
      if (CHANNELS < 2) begin : g_chk_ch
         $error("odrv_spi_direct: CHANNELS must be at least 2");
      end
   endgenerate

   logic [2:0]          pins_s;
   logic [FW-1:0]       rx_word;
   logic                frame_end, frame_ok;
   logic [CHANNELS-1:0] snap_flt, snap_lvl;

   odrv_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({sclk, cs_n, sdi}),
      .rst_val  (3'b010),
      .sync_out (pins_s)
   );

   odrv_spi_shifter #(.CH(CHANNELS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (pins_s[2]),
      .cs_n_s    (pins_s[1]),
      .sdi_s     (pins_s[0]),
      .wide_sel  (wide_sel),
      .snap_flt  (snap_flt),
      .snap_lvl  (snap_lvl),
      .sdo       (sdo),
      .rx_word   (rx_word),
      .frame_end (frame_end),
      .frame_ok  (frame_ok)
   );

   odrv_reg_bank #(.CH(CHANNELS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .frame_ok  (frame_ok),
      .wide_sel  (wide_sel),
      .cfg_sel   (cfg_sel),
      .rx_word   (rx_word),
      .flt_in    (flt_in),
      .lvl_in    (lvl_in),
      .snap_flt  (snap_flt),
      .snap_lvl  (snap_lvl),
      .level_q   (drv_level),
      .pp_q      (drv_pp),
      .ol_q      (ol_en)
   );
endmodule

// File: tb/tb_odrv_spi_direct.sv
`timescale 1ns/1ps
module tb_odrv_spi_direct;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic       sdo;
   logic       wide_sel = 1'b0, cfg_sel = 1'b0;
   logic [7:0] flt_in = '0, lvl_in = '0;
   logic [7:0] drv_level, drv_pp, ol_en;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   logic [7:0] m_lvl = '0, m_pp = '0, m_ol = '0, m_sf = '0, m_sl = '0;
   logic [15:0] ret;

   always #2.5 clk = ~clk;

   odrv_spi_direct dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
      .wide_sel(wide_sel), .cfg_sel(cfg_sel), .flt_in(flt_in), .lvl_in(lvl_in),
      .drv_level(drv_level), .drv_pp(drv_pp), .ol_en(ol_en)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      chk(req, {8'h0, drv_level}, {8'h0, m_lvl});
      chk(req, {8'h0, drv_pp},    {8'h0, m_pp});
      chk(req, {8'h0, ol_en},     {8'h0, m_ol});
   endtask

   // shift one frame of n bits; returns captured SDO bits; updates the model
   task automatic xfer(input int n, input logic [15:0] d, output logic [15:0] r);
      int need;
      r = '0;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         sdi = d[n-1-i];
         r = {r[14:0], sdo};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      sdi = 1'b0;
      repeat (2*HALF) @(negedge clk);
      need = wide_sel ? 16 : 8;
      if (n == need) begin
         case ({wide_sel, cfg_sel})
            2'b00: m_lvl = d[7:0];
            2'b01: m_pp  = d[7:0];
            2'b10: begin m_lvl = d[15:8]; m_pp = d[7:0]; end
            default: begin m_pp = d[15:8]; m_ol = d[7:0]; end
         endcase
      end
      m_sf = flt_in;
      m_sl = lvl_in;
   endtask

   task automatic t_reset;
      chk("R8 level", {8'h0, drv_level}, 16'h0);
      chk("R8 pp",    {8'h0, drv_pp},    16'h0);
      chk("R8 ol",    {8'h0, ol_en},     16'h0);
      chk("R8 sdo idle", {15'h0, sdo}, 16'h0);
   endtask

   task automatic t_narrow_level;
      logic [7:0] exp_r;
      wide_sel = 0; cfg_sel = 0;
      flt_in = 8'h3C; lvl_in = 8'h11;
      exp_r = m_sf;
      xfer(8, 16'h00A5, ret);
      chk("R8 first reply zero", {8'h0, ret[7:0]}, {8'h0, exp_r});
      chk_regs("R1 narrow level");
      flt_in = 8'hC3;
      exp_r = m_sf;
      xfer(8, 16'h0080, ret);
      chk("R5 R6 narrow fault reply", {8'h0, ret[7:0]}, {8'h0, exp_r});
      chk("R9 msb first", {8'h0, drv_level}, 16'h0080);
      chk_regs("R1 narrow level 2");
   endtask

   task automatic t_narrow_pp;
      logic [7:0] exp_r;
      cfg_sel = 1; flt_in = 8'h99;
      exp_r = m_sf;
      xfer(8, 16'h00C3, ret);
      chk("R6 reply previous", {8'h0, ret[7:0]}, {8'h0, exp_r});
      chk_regs("R2 narrow pp");
   endtask

   task automatic t_wide_lvlpp;
      logic [15:0] exp_r;
      wide_sel = 1; cfg_sel = 0;
      flt_in = 8'h5A; lvl_in = 8'hF0;
      exp_r = {m_sf, m_sl};
      xfer(16, 16'h1234, ret);
      chk("R5 wide reply", ret, exp_r);
      chk_regs("R3 wide level+pp");
      flt_in = 8'h81; lvl_in = 8'h7E;
      exp_r = {m_sf, m_sl};
      xfer(16, 16'h6E01, ret);
      chk("R5 R6 wide reply 2", ret, exp_r);
      chk_regs("R3 wide level+pp 2");
   endtask

   task automatic t_wide_ppol;
      logic [15:0] exp_r;
      wide_sel = 1; cfg_sel = 1;
      flt_in = 8'h0F; lvl_in = 8'hE1;
      exp_r = {m_sf, m_sl};
      xfer(16, 16'hABCD, ret);
      chk("R5 wide reply 3", ret, exp_r);
      chk_regs("R4 wide pp+ol");
   endtask

   task automatic t_bad_length;
      logic [15:0] exp_r;
      wide_sel = 1; cfg_sel = 0; flt_in = 8'h44; lvl_in = 8'h22;
      xfer(8, 16'h00FF, ret);
      chk_regs("R7 short wide frame");
      wide_sel = 0; cfg_sel = 0; flt_in = 8'h66;
      xfer(9, 16'h01FF, ret);
      chk_regs("R7 long narrow frame");
      cfg_sel = 1;
      xfer(16, 16'hFFFF, ret);
      chk_regs("R7 wide length in narrow mode");
      exp_r = {8'h0, m_sf};
      xfer(8, 16'h0042, ret);
      chk("R6 snapshot after discarded", {8'h0, ret[7:0]}, exp_r);
      chk_regs("R2 after discards");
      chk("R8 sdo idle end", {15'h0, sdo}, 16'h0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset;
      t_narrow_level;
      t_narrow_pp;
      t_wide_lvlpp;
      t_wide_ppol;
      t_bad_length;
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule